// File: doc/BRIEF.md
# Three-Level Translation Table Walker

This block turns a 32-bit virtual address into a 36-bit physical address. It does this by walking tables held in memory. For each accepted request it first reads an entry from a 16-entry context table, indexed by the request's 4-bit context. It then follows pointer descriptors down through three table levels, which are indexed by virtual address bits 31:24, 23:18 and 17:12. Every read and the single optional write-back go through one 32-bit memory port, which waits on a ready handshake. The walker holds no entries between walks; every request starts a fresh walk.

Every descriptor carries its type in its two lowest bits. A pointer gives the base of the next table: clear the type bits and shift the word left by four. A leaf gives a page number, a cacheable flag, referenced and modified flags, and a 3-bit access code. The access code names the rights of user mode and of supervisor mode. At the leaf, the walker checks the request's mode and access kind against that code. It then sets the referenced flag, and also the modified flag on a write. It writes the entry back only if one of these flags changes. Finally it returns the physical address and the cacheable flag, or a fault together with the level at which the walk stopped.

Top module: `xlat_walker`

## Requirements
- R1: After reset the walker is idle. In this state `req_ready` is 1, and `resp_valid` and `mem_req` are 0. A request is accepted only while `req_ready` is 1. A request offered at any other time is ignored.
- R2: The first read of a walk goes to address `ctx_base + 4*req_ctx`.
- R3: A descriptor's bits 1:0 give its type: 0 is invalid, 1 is a pointer, 2 is a leaf and 3 is reserved. A pointer word D gives the next table base `(D with bits 1:0 cleared) << 4`. The entry read at each level is base + 4*index, where the index is va[31:24] at the first level, va[23:18] at the second and va[17:12] at the third.
- R4: The walk stops with a fault in these cases. Any non-pointer descriptor at the context level gives fault level 0. At the first level it gives level 1, and at the second level it gives level 2. A non-leaf at the third level gives level 3. A faulting response carries a physical address of 0 and a cacheable flag of 0.
- R5: Leaf layout: page number in bits 31:8, cacheable in bit 7, modified in bit 6, referenced in bit 5, access code in bits 4:2. The code grants the following user/supervisor rights: 0 R/R, 1 RW/RW, 2 RX/RX, 3 RWX/RWX, 4 X/X, 5 R/RW, 6 none/RX, 7 none/RWX. A write needs W. Otherwise an execute needs X, and otherwise a read needs R. A denied access faults with level 3.
- R6: Any user-mode access to a leaf whose access code is 6 or 7 faults.
- R7: A permitted access writes back the leaf with referenced set, and with modified also set on a write. The write goes to the same address the leaf was read from.
- R8: No memory write happens when both flags already hold their target values, nor on any fault.
- R9: A successful response returns `{page number, va[11:0]}` as the 36-bit physical address. Its cacheable output equals leaf bit 7.
- R10: While `mem_req` is 1 and `mem_ready` is 0, `mem_addr`, `mem_we` and `mem_wdata` hold steady. The walk advances only on a cycle with `mem_ready` set, whatever the memory latency.
- R11: Each accepted request produces exactly one `resp_valid` pulse, one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctx_base | input | 32 | Byte address of the context table |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_va | input | 32 | Virtual address |
| req_ctx | input | 4 | Context number |
| req_write | input | 1 | Access is a write |
| req_exec | input | 1 | Access is an instruction fetch |
| req_user | input | 1 | Access made in user mode |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 36 | Memory byte address |
| mem_wdata | output | 32 | Write data (updated leaf) |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| mem_ready | input | 1 | Memory access completes this cycle |
| resp_valid | output | 1 | Response pulse |
| resp_pa | output | 36 | Physical address |
| resp_cacheable | output | 1 | Leaf cacheable flag |
| resp_fault | output | 1 | Walk ended in a fault |
| resp_fault_lvl | output | 2 | Level at which the walk faulted |

## Verification
Some internal errors show up as addresses. A wrong table base or a wrong index choice sends the very next read to a wrong location. The bench's memory then returns a zero word, and the response becomes a fault at the level that went wrong, within a few memory round trips. Other errors show up later. A wrong permission decode or flag merge appears only at the end of the walk. It shows as an unexpected fault flag, as a missing or extra write-back, or as a leaf in the bench memory with the wrong flag bits. Errors in handshake holding and in the response pulse are flagged in the very cycle they happen.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int VA_W      = 32;
    localparam int CTX_W     = 4;
    localparam int L1_W      = 8;
    localparam int L2_W      = 6;
    localparam int L3_W      = 6;
    localparam int OFF_W     = 12;
    localparam int L3_LSB    = OFF_W;
    localparam int L2_LSB    = L3_LSB + L3_W;
    localparam int L1_LSB    = L2_LSB + L2_W;
    localparam int IDX_W     = L1_W;
    localparam int DESC_W    = 32;
    localparam int TYPE_W    = 2;
    localparam int PTR_SHIFT = 4;
    localparam int ENT_SHIFT = 2;
    localparam int PA_W      = DESC_W + PTR_SHIFT;
    localparam int PPN_LSB   = 8;
    localparam int PPN_W     = DESC_W - PPN_LSB;
    localparam int BIT_C     = 7;
    localparam int BIT_M     = 6;
    localparam int BIT_R     = 5;
    localparam int ACC_LSB   = 2;
    localparam int ACC_W     = 3;

    typedef enum logic [1:0] {
        DT_INV  = 2'd0,
        DT_PTR  = 2'd1,
        DT_LEAF = 2'd2,
        DT_RSVD = 2'd3
    } dtype_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_CTX, ST_L1, ST_L2, ST_L3, ST_CHECK, ST_UPDATE, ST_DONE
    } wstate_e;

    typedef enum logic [1:0] {
        LV_CTX = 2'd0,
        LV_1   = 2'd1,
        LV_2   = 2'd2,
        LV_3   = 2'd3
    } flvl_e;

    typedef struct packed {
        logic r;
        logic w;
        logic x;
    } rights_t;

    // Rights granted by an access code in the given mode.
    function automatic rights_t rights_of(logic [ACC_W-1:0] code, logic user);
        rights_t u, s;
        case (code)
            3'd0: begin u = '{1'b1, 1'b0, 1'b0}; s = '{1'b1, 1'b0, 1'b0}; end
            3'd1: begin u = '{1'b1, 1'b1, 1'b0}; s = '{1'b1, 1'b1, 1'b0}; end
            3'd2: begin u = '{1'b1, 1'b0, 1'b1}; s = '{1'b1, 1'b0, 1'b1}; end
            3'd3: begin u = '{1'b1, 1'b1, 1'b1}; s = '{1'b1, 1'b1, 1'b1}; end
            3'd4: begin u = '{1'b0, 1'b0, 1'b1}; s = '{1'b0, 1'b0, 1'b1}; end
            3'd5: begin u = '{1'b1, 1'b0, 1'b0}; s = '{1'b1, 1'b1, 1'b0}; end
            3'd6: begin u = '{1'b0, 1'b0, 1'b0}; s = '{1'b1, 1'b0, 1'b1}; end
            default: begin u = '{1'b0, 1'b0, 1'b0}; s = '{1'b1, 1'b1, 1'b1}; end
        endcase
        return user ? u : s;
    endfunction

endpackage

// File: rtl/xlat_desc_decode.sv
module xlat_desc_decode
    import xlat_pkg::*;
(
    input  logic [DESC_W-1:0] desc,
    output dtype_e            dtype,
    output logic [PA_W-1:0]   next_base
);
    always_comb begin
        dtype     = dtype_e'(desc[TYPE_W-1:0]);
        next_base = {desc[DESC_W-1:TYPE_W], {(TYPE_W + PTR_SHIFT){1'b0}}};
    end
endmodule

// File: rtl/xlat_addr_gen.sv
module xlat_addr_gen
    import xlat_pkg::*;
(
    input  wstate_e                 state,
    input  logic [PA_W-1:0]         tbl_base,
    input  logic [CTX_W-1:0]        ctx,
    input  logic [VA_W-1:OFF_W]     vpn,
    output logic [PA_W-1:0]         addr
);
    logic [IDX_W-1:0] idx;

    always_comb begin
        case (state)
            ST_CTX:  idx = IDX_W'(ctx);
            ST_L1:   idx = IDX_W'(vpn[L1_LSB +: L1_W]);
            ST_L2:   idx = IDX_W'(vpn[L2_LSB +: L2_W]);
            default: idx = IDX_W'(vpn[L3_LSB +: L3_W]);
        endcase
        addr = tbl_base + PA_W'({idx, {ENT_SHIFT{1'b0}}});
    end
endmodule

// File: rtl/xlat_perm_check.sv
module xlat_perm_check
    import xlat_pkg::*;
(
    input  logic [DESC_W-1:0] leaf,
    input  logic              is_user,
    input  logic              is_write,
    input  logic              is_exec,
    output logic              allow,
    output logic [DESC_W-1:0] new_leaf,
    output logic              changed
);
    rights_t rg;

    always_comb begin
        rg = rights_of(leaf[ACC_LSB +: ACC_W], is_user);
        if (is_write)     allow = rg.w;
        else if (is_exec) allow = rg.x;
        else              allow = rg.r;
        new_leaf        = leaf;
        new_leaf[BIT_R] = 1'b1;
        if (is_write) new_leaf[BIT_M] = 1'b1;
        changed = (new_leaf != leaf);
    end
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
    import xlat_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [DESC_W-1:0]    ctx_base,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [VA_W-1:0]      req_va,
    input  logic [CTX_W-1:0]     req_ctx,
    input  logic                 req_write,
    input  logic                 req_exec,
    input  logic                 req_user,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [PA_W-1:0]      mem_addr,
    output logic [DESC_W-1:0]    mem_wdata,
    input  logic [DESC_W-1:0]    mem_rdata,
    input  logic                 mem_ready,
    output logic                 resp_valid,
    output logic [PA_W-1:0]      resp_pa,
    output logic                 resp_cacheable,
    output logic                 resp_fault,
    output logic [1:0]           resp_fault_lvl
);
    wstate_e            state, nxt;
    logic [PA_W-1:0]    tbl_base;
    logic [VA_W-1:0]    va_q;
    logic [CTX_W-1:0]   ctx_q;
    logic               wr_q, ex_q, us_q;
    logic [DESC_W-1:0]  leaf_q;
    logic               fault_q;
    flvl_e              flvl_q, lvl_here;

    dtype_e             rd_type;
    logic [PA_W-1:0]    rd_base;
    logic               allow, changed;
    logic [DESC_W-1:0]  new_leaf;

    xlat_desc_decode i_dec (
        .desc      (mem_rdata),
        .dtype     (rd_type),
        .next_base (rd_base)
    );

    xlat_addr_gen i_agen (
        .state    (state),
        .tbl_base (tbl_base),
        .ctx      (ctx_q),
        .vpn      (va_q[VA_W-1:OFF_W]),
        .addr     (mem_addr)
    );

    xlat_perm_check i_perm (
        .leaf     (leaf_q),
        .is_user  (us_q),
        .is_write (wr_q),
        .is_exec  (ex_q),
        .allow    (allow),
        .new_leaf (new_leaf),
        .changed  (changed)
    );

    always_comb begin
        case (state)
            ST_L1:   lvl_here = LV_1;
            ST_L2:   lvl_here = LV_2;
            ST_L3:   lvl_here = LV_3;
            default: lvl_here = LV_CTX;
        endcase
    end

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:   if (req_valid) nxt = ST_CTX;
            ST_CTX:    if (mem_ready) nxt = (rd_type == DT_PTR) ? ST_L1 : ST_DONE;
            ST_L1:     if (mem_ready) nxt = (rd_type == DT_PTR) ? ST_L2 : ST_DONE;
            ST_L2:     if (mem_ready) nxt = (rd_type == DT_PTR) ? ST_L3 : ST_DONE;
            ST_L3:     if (mem_ready) nxt = (rd_type == DT_LEAF) ? ST_CHECK : ST_DONE;
            ST_CHECK:  nxt = (allow && changed) ? ST_UPDATE : ST_DONE;
            ST_UPDATE: if (mem_ready) nxt = ST_DONE;
            ST_DONE:   nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            tbl_base <= '0;
            va_q     <= '0;
            ctx_q    <= '0;
            wr_q     <= 1'b0;
            ex_q     <= 1'b0;
            us_q     <= 1'b0;
            leaf_q   <= '0;
            fault_q  <= 1'b0;
            flvl_q   <= LV_CTX;
        end else begin
            state <= nxt;
            case (state)
                ST_IDLE: if (req_valid) begin
                    va_q     <= req_va;
                    ctx_q    <= req_ctx;
                    wr_q     <= req_write;
                    ex_q     <= req_exec;
                    us_q     <= req_user;
                    tbl_base <= PA_W'(ctx_base);
                    fault_q  <= 1'b0;
                    flvl_q   <= LV_CTX;
                end
                ST_CTX, ST_L1, ST_L2: if (mem_ready) begin
                    if (rd_type == DT_PTR) begin
                        tbl_base <= rd_base;
                    end else begin
                        fault_q <= 1'b1;
                        flvl_q  <= lvl_here;
                    end
                end
                ST_L3: if (mem_ready) begin
                    if (rd_type == DT_LEAF) begin
                        leaf_q <= mem_rdata;
                    end else begin
                        fault_q <= 1'b1;
                        flvl_q  <= LV_3;
                    end
                end
                ST_CHECK: if (!allow) begin
                    fault_q <= 1'b1;
                    flvl_q  <= LV_3;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        req_ready      = (state == ST_IDLE);
        mem_req        = (state == ST_CTX) || (state == ST_L1) || (state == ST_L2) ||
                         (state == ST_L3)  || (state == ST_UPDATE);
        mem_we         = (state == ST_UPDATE);
        mem_wdata      = new_leaf;
        resp_valid     = (state == ST_DONE);
        resp_fault     = fault_q;
        resp_fault_lvl = flvl_q;
        resp_pa        = fault_q ? '0 : {leaf_q[DESC_W-1:PPN_LSB], va_q[OFF_W-1:0]};
        resp_cacheable = !fault_q && leaf_q[BIT_C];
    end

endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk
    import xlat_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              resp_valid,
    input logic              resp_fault,
    input logic [PA_W-1:0]   resp_pa,
    input logic              resp_cacheable,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ready,
    input logic [PA_W-1:0]   mem_addr,
    input logic [DESC_W-1:0] mem_wdata
);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !mem_req && !resp_valid);

    a_r4_fault_zero_out: assert property (@(posedge clk) disable iff (rst)
        resp_valid && resp_fault |-> resp_pa == '0 && !resp_cacheable);

    a_r7_write_sets_ref: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_req && mem_wdata[BIT_R]);

    a_r10_hold_stable: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid);

    a_r11_not_ready_on_resp: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> !req_ready);
endmodule

bind xlat_walker xlat_walker_chk i_chk (
    .clk            (clk),
    .rst            (rst),
    .req_ready      (req_ready),
    .resp_valid     (resp_valid),
    .resp_fault     (resp_fault),
    .resp_pa        (resp_pa),
    .resp_cacheable (resp_cacheable),
    .mem_req        (mem_req),
    .mem_we         (mem_we),
    .mem_ready      (mem_ready),
    .mem_addr       (mem_addr),
    .mem_wdata      (mem_wdata)
);

// File: tb/test_xlat_walker.sv
module test_xlat_walker;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] ctx_base;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_va;
    logic [3:0]  req_ctx;
    logic        req_write, req_exec, req_user;
    logic        mem_req, mem_we;
    logic [35:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        mem_ready;
    logic        resp_valid;
    logic [35:0] resp_pa;
    logic        resp_cacheable, resp_fault;
    logic [1:0]  resp_fault_lvl;

    always #4 clk = ~clk;

    xlat_walker i_xlat_walker (.*);

    localparam logic [35:0] CB  = 36'h1000;
    localparam logic [35:0] L1B = 36'h2000;
    localparam logic [35:0] L2B = 36'h3000;
    localparam logic [35:0] L3B = 36'h4000;

    logic [31:0] mem [logic [35:0]];
    int          lat;
    int          wait_cnt;
    int          wr_cnt;
    logic [35:0] last_wr_addr;
    logic [35:0] first_rd_addr;
    logic        first_seen;
    int          resp_cnt;
    int          n_chk, n_fail;

    function automatic logic [31:0] rd_word(input logic [35:0] a);
        if (mem.exists(a)) return mem[a];
        return 32'h0;
    endfunction

    // memory responder: ready one cycle after lat wait cycles
    always @(posedge clk) begin
        if (rst) begin
            mem_ready <= 1'b0;
            wait_cnt  <= 0;
        end else if (mem_ready) begin
            mem_ready <= 1'b0;
            wait_cnt  <= 0;
        end else if (mem_req) begin
            if (!first_seen) begin
                first_seen    = 1'b1;
                first_rd_addr <= mem_addr;
            end
            if (wait_cnt >= lat) begin
                mem_ready <= 1'b1;
                if (mem_we) begin
                    mem[mem_addr] = mem_wdata;
                    wr_cnt       <= wr_cnt + 1;
                    last_wr_addr <= mem_addr;
                end else begin
                    mem_rdata <= rd_word(mem_addr);
                end
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end
    end

    always @(posedge clk) if (!rst && resp_valid) resp_cnt <= resp_cnt + 1;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    function automatic logic [31:0] ptd(input logic [35:0] base);
        return {base[35:6], 2'b01};
    endfunction

    function automatic logic [31:0] leaf(input logic [23:0] ppn, input bit c, input logic [2:0] acc);
        return {ppn, c, 1'b0, 1'b0, acc, 2'b10};
    endfunction

    function automatic logic [35:0] l3_addr(input logic [31:0] va);
        return L3B + 36'(va[17:12]) * 4;
    endfunction

    task automatic build(input logic [3:0] ctx, input logic [31:0] va, input logic [31:0] lf);
        mem[CB + 36'(ctx) * 4]       = ptd(L1B);
        mem[L1B + 36'(va[31:24]) * 4] = ptd(L2B);
        mem[L2B + 36'(va[23:18]) * 4] = ptd(L3B);
        mem[l3_addr(va)]              = lf;
    endtask

    logic [35:0] g_pa;
    logic        g_c, g_f;
    logic [1:0]  g_l;
    int          g_wr;

    task automatic walk(input logic [31:0] va, input logic [3:0] ctx,
                        input bit w, input bit x, input bit u);
        int w0, t;
        w0 = wr_cnt;
        first_seen = 1'b0;
        @(negedge clk);
        req_va = va; req_ctx = ctx; req_write = w; req_exec = x; req_user = u;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        t = 0;
        while (!resp_valid && t < 300) begin
            @(negedge clk);
            t++;
        end
        g_pa = resp_pa; g_c = resp_cacheable; g_f = resp_fault; g_l = resp_fault_lvl;
        @(negedge clk);
        g_wr = wr_cnt - w0;
    endtask

    task automatic t_reset;
        chk(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 1);
        chk(resp_valid == 1'b0, "R1 no resp after reset", 64'(resp_valid), 0);
        chk(mem_req == 1'b0, "R1 no mem after reset", 64'(mem_req), 0);
    endtask

    task automatic t_sup_read;
        logic [31:0] va = 32'h12_34_5abc;
        build(4'd3, va, leaf(24'hABCDE1, 1'b1, 3'd0));
        walk(va, 4'd3, 0, 0, 0);
        chk(first_rd_addr == CB + 36'd12, "R2 ctx entry address", 64'(first_rd_addr), 64'(CB + 36'd12));
        chk(g_f == 1'b0, "R3 walk completes", 64'(g_f), 0);
        chk(g_pa == {24'hABCDE1, 12'habc}, "R9 physical address", 64'(g_pa), 64'({24'hABCDE1, 12'habc}));
        chk(g_c == 1'b1, "R9 cacheable", 64'(g_c), 1);
        chk(g_wr == 1, "R7 one write-back", 64'(g_wr), 1);
        chk(last_wr_addr == l3_addr(va), "R7 write-back address", 64'(last_wr_addr), 64'(l3_addr(va)));
        chk(mem[l3_addr(va)] == (leaf(24'hABCDE1, 1'b1, 3'd0) | 32'h20), "R7 referenced set",
            64'(mem[l3_addr(va)]), 64'(leaf(24'hABCDE1, 1'b1, 3'd0) | 32'h20));
        // repeat: referenced already set
        walk(va, 4'd3, 0, 0, 0);
        chk(g_wr == 0, "R8 no write when unchanged", 64'(g_wr), 0);
        chk(g_f == 1'b0 && g_c == 1'b1, "R9 repeat read ok", 64'({g_f, g_c}), 1);
    endtask

    task automatic t_user_write;
        logic [31:0] va = 32'h80_4c_1010;
        build(4'd1, va, leaf(24'h000777, 1'b0, 3'd1));
        walk(va, 4'd1, 1, 0, 1);
        chk(g_f == 1'b0, "R5 user write code 1", 64'(g_f), 0);
        chk(g_c == 1'b0, "R9 non-cacheable", 64'(g_c), 0);
        chk(mem[l3_addr(va)] == (leaf(24'h000777, 1'b0, 3'd1) | 32'h60), "R7 modified and referenced",
            64'(mem[l3_addr(va)]), 64'(leaf(24'h000777, 1'b0, 3'd1) | 32'h60));
        // write denied on code 0
        build(4'd1, va, leaf(24'h000777, 1'b0, 3'd0));
        walk(va, 4'd1, 1, 0, 0);
        chk(g_f == 1'b1 && g_l == 2'd3, "R5 write denied code 0", 64'({g_f, g_l}), 64'h7);
        chk(g_wr == 0, "R8 no write on fault", 64'(g_wr), 0);
        chk(mem[l3_addr(va)] == leaf(24'h000777, 1'b0, 3'd0), "R8 leaf untouched",
            64'(mem[l3_addr(va)]), 64'(leaf(24'h000777, 1'b0, 3'd0)));
        chk(g_pa == 36'h0, "R4 fault pa zero", 64'(g_pa), 0);
    endtask

    task automatic t_codes;
        logic [31:0] va = 32'h05_08_3000;
        build(4'd2, va, leaf(24'h100000, 1'b1, 3'd6));
        walk(va, 4'd2, 0, 0, 1);
        chk(g_f == 1'b1 && g_l == 2'd3, "R6 user read code 6", 64'({g_f, g_l}), 64'h7);
        walk(va, 4'd2, 0, 1, 0);
        chk(g_f == 1'b0, "R5 supervisor exec code 6", 64'(g_f), 0);
        build(4'd2, va, leaf(24'h100000, 1'b1, 3'd7));
        walk(va, 4'd2, 0, 1, 1);
        chk(g_f == 1'b1, "R6 user exec code 7", 64'(g_f), 1);
        build(4'd2, va, leaf(24'h100000, 1'b1, 3'd4));
        walk(va, 4'd2, 0, 0, 1);
        chk(g_f == 1'b1, "R5 read code 4 denied", 64'(g_f), 1);
        walk(va, 4'd2, 0, 1, 1);
        chk(g_f == 1'b0, "R5 user exec code 4", 64'(g_f), 0);
        build(4'd2, va, leaf(24'h100000, 1'b1, 3'd5));
        walk(va, 4'd2, 1, 0, 0);
        chk(g_f == 1'b0, "R5 supervisor write code 5", 64'(g_f), 0);
        build(4'd2, va, leaf(24'h100000, 1'b1, 3'd5));
        walk(va, 4'd2, 1, 0, 1);
        chk(g_f == 1'b1, "R5 user write code 5", 64'(g_f), 1);
        build(4'd2, va, leaf(24'h100000, 1'b1, 3'd2));
        walk(va, 4'd2, 1, 1, 0);
        chk(g_f == 1'b1, "R5 write wins over exec", 64'(g_f), 1);
    endtask

    task automatic t_struct_faults;
        logic [31:0] va = 32'hFF_FC_F123;
        build(4'd9, va, leaf(24'h0ABCDE, 1'b1, 3'd3));
        mem[CB + 36'd36] = 32'h0;
        walk(va, 4'd9, 0, 0, 0);
        chk(g_f == 1'b1 && g_l == 2'd0, "R4 invalid at context", 64'({g_f, g_l}), 64'h4);
        build(4'd9, va, leaf(24'h0ABCDE, 1'b1, 3'd3));
        mem[L1B + 36'(va[31:24]) * 4] = leaf(24'h1, 1'b1, 3'd3);
        walk(va, 4'd9, 0, 0, 0);
        chk(g_f == 1'b1 && g_l == 2'd1, "R4 leaf at level 1", 64'({g_f, g_l}), 64'h5);
        chk(g_c == 1'b0, "R4 fault not cacheable", 64'(g_c), 0);
        build(4'd9, va, leaf(24'h0ABCDE, 1'b1, 3'd3));
        mem[L2B + 36'(va[23:18]) * 4] = 32'h3;
        walk(va, 4'd9, 0, 0, 0);
        chk(g_f == 1'b1 && g_l == 2'd2, "R4 reserved at level 2", 64'({g_f, g_l}), 64'h6);
        build(4'd9, va, ptd(L1B));
        walk(va, 4'd9, 0, 0, 0);
        chk(g_f == 1'b1 && g_l == 2'd3, "R4 pointer at level 3", 64'({g_f, g_l}), 64'h7);
        chk(g_wr == 0, "R8 no write on structural fault", 64'(g_wr), 0);
    endtask

    task automatic t_latency;
        logic [31:0] va = 32'h3C_A4_0FFF;
        lat = 3;
        build(4'd15, va, leaf(24'hFEDCBA, 1'b0, 3'd3) | 32'h20);
        walk(va, 4'd15, 1, 0, 1);
        chk(first_rd_addr == CB + 36'd60, "R2 ctx 15 address", 64'(first_rd_addr), 64'(CB + 36'd60));
        chk(g_f == 1'b0 && g_pa == {24'hFEDCBA, 12'hFFF}, "R10 slow memory walk",
            64'(g_pa), 64'({24'hFEDCBA, 12'hFFF}));
        chk(mem[l3_addr(va)] == (leaf(24'hFEDCBA, 1'b0, 3'd3) | 32'h60), "R7 modified added",
            64'(mem[l3_addr(va)]), 64'(leaf(24'hFEDCBA, 1'b0, 3'd3) | 32'h60));
        lat = 0;
    endtask

    task automatic t_busy;
        logic [31:0] va = 32'h44_10_2345;
        int r0;
        build(4'd4, va, leaf(24'h222222, 1'b1, 3'd3));
        build(4'd5, 32'h99_00_0000, leaf(24'h333333, 1'b0, 3'd3));
        lat = 2;
        r0 = resp_cnt;
        @(negedge clk);
        req_va = va; req_ctx = 4'd4; req_write = 0; req_exec = 0; req_user = 0;
        req_valid = 1'b1;
        @(negedge clk);
        req_va = 32'h99_00_0000; req_ctx = 4'd5;
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        while (!resp_valid) @(negedge clk);
        g_pa = resp_pa;
        repeat (20) @(negedge clk);
        chk(g_pa == {24'h222222, 12'h345}, "R1 busy request ignored", 64'(g_pa), 64'({24'h222222, 12'h345}));
        chk(resp_cnt - r0 == 1, "R11 one response per request", 64'(resp_cnt - r0), 1);
        lat = 0;
    endtask

    initial begin
        n_chk = 0; n_fail = 0; lat = 0; wr_cnt = 0; resp_cnt = 0;
        first_seen = 1'b1; first_rd_addr = '0; last_wr_addr = '0; mem_rdata = '0;
        ctx_base = 32'(CB);
        req_valid = 0; req_va = 0; req_ctx = 0; req_write = 0; req_exec = 0; req_user = 0;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_sup_read();
        t_user_write();
        t_codes();
        t_struct_faults();
        t_latency();
        t_busy();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end
endmodule